// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing fields of one instruction operand into the location of that operand. Each request carries a mode code, two register indices, a signed value or offset field, an absolute address field, the current program counter and an operand size code. The block reads a small internal register file through two combinational read ports and produces one of three results. For immediate mode it returns the operand value itself. For register mode it returns a register name. For every other mode it returns an effective address.

All modes except memory-indirect complete one clock after the request is taken. Memory-indirect mode issues a single-cycle read request for the address field and waits for the returned word, which then becomes the effective address. The post-increment and pre-decrement modes move the base register by the operand size and report that update on a one-cycle write-back output. The register file is filled through a load port. Address arithmetic is 32-bit two's complement and wraps without any flag.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode code 0 (immediate) returns `xval` on `imm_val` with `is_imm` high and `ea_valid` high, and `ea` reads 0.
- R2: Mode code 1 (register) raises `is_reg` with `reg_idx` equal to `ri`, and `ea` reads 0. `is_imm` and `is_reg` are never high together.
- R3: Mode code 2 (absolute) returns `loc` unchanged as `ea`.
- R4: Mode code 3 (register indirect) gives `ea` = [ri]. Mode code 5 (indexed) gives `ea` = [ri] + `xval`.
- R5: Mode code 6 gives `ea` = [ri] + [rj]. Mode code 7 gives `ea` = [ri] + [rj] + `xval`.
- R6: Mode code 8 (PC-relative) gives `ea` = `pc` + `xval`.
- R7: Mode code 4 (memory indirect) raises `mem_rd_req` for exactly one cycle with `mem_rd_addr` = `loc` and sets `busy`. One cycle after `mem_rd_valid` arrives, `ea_valid` is high, `ea` equals the returned `mem_rd_data` and `busy` is low.
- R8: Mode code 9 (post-increment) gives `ea` = [ri] and writes back [ri] + step. The step is 1, 2, 4 or 4 bytes for `opsize` codes 0, 1, 2 or 3.
- R9: Mode code 10 (pre-decrement) gives `ea` = [ri] − step and writes that same value back to ri.
- R10: `wb_en` pulses only for modes 9 and 10, together with `wb_idx` = `ri` and the new value on `wb_data`. The register holds the new value for the next request.
- R11: Every addition and subtraction wraps modulo 2^32, and no overflow indication exists.
- R12: A request presented while `busy` is high is ignored: it gives no result and no write-back, and it changes no register.
- R13: While reset is high, all outputs are 0, and all registers read 0 after reset.
- R14: A non-memory-indirect request taken at a clock edge gives its result right after that edge. `ea_valid` stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| ri | input | IDX_W | First register index |
| rj | input | IDX_W | Second register index |
| xval | input | 32 | Signed value / offset field |
| loc | input | 32 | Absolute address field |
| pc | input | 32 | Current program counter |
| opsize | input | 2 | Operand size code for auto modes |
| ld_en | input | 1 | Register file load strobe |
| ld_idx | input | IDX_W | Register file load index |
| ld_data | input | 32 | Register file load data |
| mem_rd_req | output | 1 | Indirect read request pulse |
| mem_rd_addr | output | 32 | Indirect read address |
| mem_rd_valid | input | 1 | Indirect read data strobe |
| mem_rd_data | input | 32 | Indirect read data |
| busy | output | 1 | Waiting for indirect read data |
| ea_valid | output | 1 | Result pulse |
| ea | output | 32 | Effective address |
| is_imm | output | 1 | Result is an immediate operand |
| imm_val | output | 32 | Immediate operand value |
| is_reg | output | 1 | Result names a register |
| reg_idx | output | IDX_W | Named register index |
| wb_en | output | 1 | Register write-back pulse |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
The assertions assume that `mem_rd_valid` is meaningful only while `busy` is high. They also assume that the load port is not used in the same cycle as an auto-mode request to the same register. The directed stimulus returns read data only after the request pulse, and performs every register load before any address request. It also places a request inside the busy window so that the ignore rule is exercised.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    parameter int DATA_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        M_IMM   = 4'd0,
        M_REG   = 4'd1,
        M_ABS   = 4'd2,
        M_RIND  = 4'd3,
        M_MIND  = 4'd4,
        M_IDX   = 4'd5,
        M_BIDX  = 4'd6,
        M_BIDXO = 4'd7,
        M_REL   = 4'd8,
        M_AINC  = 4'd9,
        M_ADEC  = 4'd10
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        word_t ea;
        word_t imm;
        logic  is_imm;
        logic  is_reg;
        logic  wb_en;
        word_t wb_data;
        logic  mem_req;
    } calc_t;

    function automatic word_t step_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    step_bytes = word_t'(1);
            2'd1:    step_bytes = word_t'(2);
            default: step_bytes = word_t'(4);
        endcase
    endfunction

endpackage

// File: rtl/eagu_regfile.sv
module eagu_regfile
    import eagu_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    output word_t         rd_a,
    output word_t         rd_b,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  word_t         wb_data,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  word_t         ld_data
);

    word_t regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wb_en && (wb_idx == IW'(g))) begin
                regs[g] <= wb_data;
            end else if (ld_en && (ld_idx == IW'(g))) begin
                regs[g] <= ld_data;
            end
        end
    end

    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
    import eagu_pkg::*;
(
    input  mode_e      mode,
    input  word_t      ri_val,
    input  word_t      rj_val,
    input  word_t      xval,
    input  word_t      loc,
    input  word_t      pc,
    input  logic [1:0] opsize,
    output calc_t      res
);

    word_t step;
    word_t dec_val;

    assign step    = step_bytes(opsize);
    assign dec_val = ri_val - step;

    always_comb begin
        res = '0;
        case (mode)
            M_IMM: begin
                res.is_imm = 1'b1;
                res.imm    = xval;
            end
            M_REG:   res.is_reg = 1'b1;
            M_ABS:   res.ea     = loc;
            M_RIND:  res.ea     = ri_val;
            M_MIND:  res.mem_req = 1'b1;
            M_IDX:   res.ea     = ri_val + xval;
            M_BIDX:  res.ea     = ri_val + rj_val;
            M_BIDXO: res.ea     = ri_val + rj_val + xval;
            M_REL:   res.ea     = pc + xval;
            M_AINC: begin
                res.ea      = ri_val;
                res.wb_en   = 1'b1;
                res.wb_data = ri_val + step;
            end
            M_ADEC: begin
                res.ea      = dec_val;
                res.wb_en   = 1'b1;
                res.wb_data = dec_val;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import eagu_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [3:0]       mode,
    input  logic [IDX_W-1:0] ri,
    input  logic [IDX_W-1:0] rj,
    input  logic [31:0]      xval,
    input  logic [31:0]      loc,
    input  logic [31:0]      pc,
    input  logic [1:0]       opsize,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_data,
    output logic             mem_rd_req,
    output logic [31:0]      mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [31:0]      mem_rd_data,
    output logic             busy,
    output logic             ea_valid,
    output logic [31:0]      ea,
    output logic             is_imm,
    output logic [31:0]      imm_val,
    output logic             is_reg,
    output logic [IDX_W-1:0] reg_idx,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [31:0]      wb_data
);

    state_e state;
    mode_e  mode_q;
    word_t  ri_val;
    word_t  rj_val;
    calc_t  res;
    logic   accept;
    logic   rf_wb;

    assign mode_q = mode_e'(mode);
    assign accept = req_valid && (state == ST_IDLE);
    assign rf_wb  = accept && res.wb_en;
    assign busy   = (state == ST_WAIT);

    eagu_regfile #(.NREGS(NREGS)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ri),
        .rd_b_idx (rj),
        .rd_a     (ri_val),
        .rd_b     (rj_val),
        .wb_en    (rf_wb),
        .wb_idx   (ri),
        .wb_data  (res.wb_data),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_data  (ld_data)
    );

    eagu_calc u_calc (
        .mode   (mode_q),
        .ri_val (ri_val),
        .rj_val (rj_val),
        .xval   (xval),
        .loc    (loc),
        .pc     (pc),
        .opsize (opsize),
        .res    (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            ea_valid    <= 1'b0;
            ea          <= '0;
            is_imm      <= 1'b0;
            imm_val     <= '0;
            is_reg      <= 1'b0;
            reg_idx     <= '0;
            wb_en       <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
        end else begin
            mem_rd_req <= 1'b0;
            ea_valid   <= 1'b0;
            is_imm     <= 1'b0;
            is_reg     <= 1'b0;
            wb_en      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (res.mem_req) begin
                            mem_rd_req  <= 1'b1;
                            mem_rd_addr <= loc;
                            state       <= ST_WAIT;
                        end else begin
                            ea_valid <= 1'b1;
                            ea       <= res.ea;
                            is_imm   <= res.is_imm;
                            imm_val  <= res.imm;
                            is_reg   <= res.is_reg;
                            reg_idx  <= ri;
                            wb_en    <= res.wb_en;
                            wb_idx   <= ri;
                            wb_data  <= res.wb_data;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        ea_valid <= 1'b1;
                        ea       <= mem_rd_data;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eagu_checker.sv
module eagu_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  mode,
    input logic [31:0] xval,
    input logic [31:0] pc,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_data,
    input logic        mem_rd_req,
    input logic        busy,
    input logic        ea_valid,
    input logic [31:0] ea,
    input logic        is_imm,
    input logic [31:0] imm_val,
    input logic        is_reg,
    input logic        wb_en
);

    a_r1_imm_result: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode == 4'd0) |=> (ea_valid && is_imm && imm_val == $past(xval)));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({is_imm, is_reg}));

    a_r2_flags_with_valid: assert property (@(posedge clk) disable iff (rst)
        (is_imm || is_reg) |-> ea_valid);

    a_r6_relative: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode == 4'd8) |=> (ea_valid && ea == $past(pc) + $past(xval)));

    a_r7_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

    a_r7_complete: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rd_valid) |=> (ea_valid && !busy && ea == $past(mem_rd_data)));

    a_r10_wb_auto_only: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(req_valid && !busy && (mode == 4'd9 || mode == 4'd10)));

    a_r12_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!wb_en && !ea_valid));

endmodule

bind addr_gen_unit eagu_checker u_eagu_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .mode         (mode),
    .xval         (xval),
    .pc           (pc),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_req   (mem_rd_req),
    .busy         (busy),
    .ea_valid     (ea_valid),
    .ea           (ea),
    .is_imm       (is_imm),
    .imm_val      (imm_val),
    .is_reg       (is_reg),
    .wb_en        (wb_en)
);

// File: tb/tb_addr_gen_unit.sv
module tb_addr_gen_unit;
    import eagu_pkg::*;

    localparam int CLK_P = 10;
    localparam int NREGS = 8;
    localparam int IW    = $clog2(NREGS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    mode = '0;
    logic [IW-1:0] ri = '0, rj = '0;
    logic [31:0]   xval = '0, loc = '0, pc = '0;
    logic [1:0]    opsize = '0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [31:0]   ld_data = '0;
    logic          mem_rd_req;
    logic [31:0]   mem_rd_addr;
    logic          mem_rd_valid = 1'b0;
    logic [31:0]   mem_rd_data = '0;
    logic          busy, ea_valid, is_imm, is_reg, wb_en;
    logic [31:0]   ea, imm_val, wb_data;
    logic [IW-1:0] reg_idx, wb_idx;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    addr_gen_unit #(.NREGS(NREGS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .ri(ri), .rj(rj), .xval(xval), .loc(loc), .pc(pc), .opsize(opsize),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .busy(busy), .ea_valid(ea_valid), .ea(ea), .is_imm(is_imm),
        .imm_val(imm_val), .is_reg(is_reg), .reg_idx(reg_idx),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic load_reg(input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IW'(idx); ld_data = val;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic apply(input mode_e m, input int a, input int b,
                         input logic [31:0] x, input logic [31:0] l,
                         input logic [31:0] p, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; mode = 4'(m); ri = IW'(a); rj = IW'(b);
        xval = x; loc = l; pc = p; opsize = sz;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        chk("R13", "ea_valid", 32'(ea_valid), 0);
        chk("R13", "mem_rd_req", 32'(mem_rd_req), 0);
        chk("R13", "wb_en", 32'(wb_en), 0);
        chk("R13", "ea", ea, 0);
        @(negedge clk); rst = 1'b0;
        apply(M_RIND, 1, 0, 0, 0, 0, 0);
        chk("R13", "register after reset", ea, 0);
    endtask

    task automatic t_imm_reg_abs;
        apply(M_IMM, 0, 0, 32'hFFFF_FF85, 32'h1234, 0, 0);
        chk("R1", "is_imm", 32'(is_imm), 1);
        chk("R1", "imm_val", imm_val, 32'hFFFF_FF85);
        chk("R1", "ea", ea, 0);
        chk("R2", "is_reg with imm", 32'(is_reg), 0);
        apply(M_REG, 5, 0, 0, 0, 0, 0);
        chk("R2", "is_reg", 32'(is_reg), 1);
        chk("R2", "reg_idx", 32'(reg_idx), 5);
        chk("R2", "is_imm with reg", 32'(is_imm), 0);
        apply(M_ABS, 0, 0, 32'h55, 32'hDEAD_0000, 0, 0);
        chk("R3", "ea", ea, 32'hDEAD_0000);
        chk("R14", "ea_valid", 32'(ea_valid), 1);
        @(posedge clk); #1;
        chk("R14", "ea_valid one cycle", 32'(ea_valid), 0);
    endtask

    task automatic t_reg_modes;
        apply(M_RIND, 1, 0, 0, 0, 0, 0);
        chk("R4", "indirect", ea, 32'h1000);
        apply(M_IDX, 1, 0, 32'hFFFF_FFF0, 0, 0, 0);
        chk("R4", "indexed", ea, 32'h0FF0);
        apply(M_BIDX, 1, 2, 32'h7, 0, 0, 0);
        chk("R5", "base+index", ea, 32'h1020);
        apply(M_BIDXO, 1, 2, 32'h4, 0, 0, 0);
        chk("R5", "base+index+offset", ea, 32'h1024);
        apply(M_REL, 0, 0, 32'hFFFF_FFF8, 0, 32'h400, 0);
        chk("R6", "relative", ea, 32'h3F8);
        apply(M_IDX, 3, 0, 32'h20, 0, 0, 0);
        chk("R11", "wrap", ea, 32'h10);
        chk("R10", "no wb in indexed", 32'(wb_en), 0);
    endtask

    task automatic t_auto;
        apply(M_AINC, 4, 0, 0, 0, 0, 2'd1);
        chk("R8", "ea step2", ea, 32'h100);
        chk("R10", "wb_en", 32'(wb_en), 1);
        chk("R10", "wb_idx", 32'(wb_idx), 4);
        chk("R8", "wb_data step2", wb_data, 32'h102);
        apply(M_AINC, 4, 0, 0, 0, 0, 2'd0);
        chk("R8", "ea step1", ea, 32'h102);
        chk("R8", "wb_data step1", wb_data, 32'h103);
        apply(M_AINC, 4, 0, 0, 0, 0, 2'd2);
        chk("R8", "wb_data step4", wb_data, 32'h107);
        apply(M_RIND, 4, 0, 0, 0, 0, 0);
        chk("R10", "register updated", ea, 32'h107);
        chk("R10", "wb_en low", 32'(wb_en), 0);
        apply(M_ADEC, 4, 0, 0, 0, 0, 2'd3);
        chk("R9", "ea predec", ea, 32'h103);
        chk("R9", "wb_data predec", wb_data, 32'h103);
        apply(M_ADEC, 6, 0, 0, 0, 0, 2'd0);
        chk("R11", "predec wrap", ea, 32'hFFFF_FFFF);
        apply(M_RIND, 6, 0, 0, 0, 0, 0);
        chk("R9", "register after predec", ea, 32'hFFFF_FFFF);
    endtask

    task automatic t_mem_indirect;
        apply(M_MIND, 0, 0, 0, 32'h2000, 0, 0);
        chk("R7", "mem_rd_req", 32'(mem_rd_req), 1);
        chk("R7", "mem_rd_addr", mem_rd_addr, 32'h2000);
        chk("R7", "busy", 32'(busy), 1);
        chk("R7", "no early ea_valid", 32'(ea_valid), 0);
        apply(M_AINC, 4, 0, 0, 0, 0, 2'd2);
        chk("R7", "req one cycle", 32'(mem_rd_req), 0);
        chk("R12", "no wb while busy", 32'(wb_en), 0);
        chk("R12", "no result while busy", 32'(ea_valid), 0);
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = 32'hCAFE_0000;
        @(posedge clk); #1;
        mem_rd_valid = 1'b0;
        chk("R7", "ea_valid", 32'(ea_valid), 1);
        chk("R7", "ea", ea, 32'hCAFE_0000);
        chk("R7", "busy cleared", 32'(busy), 0);
        apply(M_RIND, 4, 0, 0, 0, 0, 0);
        chk("R12", "register untouched", ea, 32'h103);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset;
        load_reg(1, 32'h1000);
        load_reg(2, 32'h20);
        load_reg(3, 32'hFFFF_FFF0);
        load_reg(4, 32'h100);
        t_imm_reg_abs;
        t_reg_modes;
        t_auto;
        t_mem_indirect;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule